// File: doc/BRIEF.md
# Four-Channel Buffered Pulse-Width Modulator

This block produces one pulse-width modulated waveform per channel. Software reaches it over a simple register bus. Each channel has three pieces of state:

- a mode word, which selects a power-of-two clock prescaler and the output polarity;
- an active period value and an active duty value;
- a pair of staging registers.

A value written to a staging register is held. It is copied into the active register only when the channel finishes a full period. Software can therefore retune a running channel without producing a truncated or stretched pulse.

Three global registers control and report the channels:

- a write-one-to-set start register;
- a write-one stop request register;
- a read-only running mask.

A sticky per-channel completion flag is set each time a period ends. Software reads the flag word to confirm that staged values have landed, and that read clears the word. A stop request is not acted on at once. The channel completes its current period and then halts. Its running bit stays high until that happens.

Top module: `pwm_ctrl`

## Requirements
- R1: After reset every output is 0, the running mask (offset 0x0C) reads 0 and the flag word (offset 0x1C) reads 0.
- R2: Writing offset 0x04 starts each channel whose data bit i is 1. Channel i shows as running in bit i of offset 0x0C. Data bits that are 0 leave their channels unchanged.
- R3: The channel counter advances once every 2^p clocks, where p is mode bits [3:0]. A value of p above 10 behaves as 10.
- R4: The counter runs from 0 to period-1 and then wraps. The output is active while count < duty. One period lasts period*2^p clocks and the active time lasts duty*2^p clocks.
- R5: Mode bit 9 selects the active level: 0 selects high and 1 selects low. A channel that is not running drives the inactive level.
- R6: A duty of 0 gives a constant inactive output. A duty at or above the period gives a constant active output.
- R7: A value written to the duty staging register (+0x08) or the period staging register (+0x10) is applied only at the end of the channel's current period. Until then the active register (+0x04 or +0x0C) reads back the old value.
- R8: Bit i of offset 0x1C is set when channel i ends a period. A read of 0x1C returns the word and clears it, except for bits set in that same cycle.
- R9: Writing bit i to offset 0x08 stops channel i only at the end of its current period. The running bit stays 1 until then, and the output then goes to the inactive level.
- R10: Only the low 16 bits of a period or duty write are stored. Upper bits are ignored.
- R11: A start write to a channel that is already running restarts its counter and prescaler from zero.
- R12: A write to the active duty (+0x04) or active period (+0x0C) register takes effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 10 | Byte address; channel n window at 0x200 + n*0x20 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the strobe |
| pwm_out | output | 4 | One waveform per channel |

## Verification
The assertions assume that each bus strobe lasts one cycle. They also assume that a staging write to a channel does not fall in the same cycle as a direct write to the same field. The stimulus issues single-cycle accesses from tasks with idle gaps between them, and it never issues such a collision. A behavioural model in the bench tracks every channel, every flag and every read response. It is compared against the outputs on every clock. Directed counts of active clocks and directed register reads then pin down the period-boundary effects.

// File: rtl/pwm_ctrl_pkg.sv
// Package: shared sizes and register offsets for the PWM controller.
// Assumes byte addressing with 32-bit aligned registers.
package pwm_ctrl_pkg;
    localparam int NCH_DEF    = 4;
    localparam int CNT_W_DEF  = 16;
    localparam int PRES_W_DEF = 4;
    localparam int PRES_MAX   = 10;
    localparam int ADDR_W_DEF = 10;
    localparam int DATA_W_DEF = 32;
    localparam int CH_LSB     = 5;      // channel window is 32 bytes
    localparam int POL_BIT    = 9;

    localparam logic [4:0] G_START = 5'h04;
    localparam logic [4:0] G_STOP  = 5'h08;
    localparam logic [4:0] G_RUN   = 5'h0C;
    localparam logic [4:0] G_FLAG  = 5'h1C;

    localparam logic [4:0] C_MODE  = 5'h00;
    localparam logic [4:0] C_DUTY  = 5'h04;
    localparam logic [4:0] C_DSTG  = 5'h08;
    localparam logic [4:0] C_PER   = 5'h0C;
    localparam logic [4:0] C_PSTG  = 5'h10;
endpackage

// File: rtl/pwm_tick_gen.sv
// Module: pwm_tick_gen
// Produces a one-cycle tick every 2^sel clocks while run is high.
// sel is the requested exponent clamped to PRES_MAX. A restart or an
// idle channel holds the divider at zero.
module pwm_tick_gen #(
    parameter int PRES_W   = 4,
    parameter int PRES_MAX = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [PRES_W-1:0] pres,
    output logic              tick
);
    localparam int DIV_W = PRES_MAX;

    logic [PRES_W-1:0] sel;
    logic [DIV_W:0]    full;
    logic [DIV_W-1:0]  lim;
    logic [DIV_W-1:0]  pre;

    // Clamp the exponent and form the terminal divider count.
    always_comb begin
        sel  = (pres > PRES_W'(PRES_MAX)) ? PRES_W'(PRES_MAX) : pres;
        full = (DIV_W+1)'(1) << sel;
        lim  = DIV_W'(full - (DIV_W+1)'(1));
    end

    assign tick = run && (pre == lim);

    // Divider counter: cleared on restart, when idle or after a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pre <= '0;
        else if (restart || !run)    pre <= '0;
        else if (tick)               pre <= '0;
        else                         pre <= pre + DIV_W'(1);
    end

    // R3: with any division above one, two ticks never come back to back.
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> (!tick || sel == '0));
endmodule

// File: rtl/pwm_channel.sv
// Module: pwm_channel
// One PWM channel: period counter, staged duty and period, start and
// deferred stop, and the output level. Assumes single-cycle write strobes.
module pwm_channel #(
    parameter int CNT_W    = 16,
    parameter int PRES_W   = 4,
    parameter int PRES_MAX = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              wr_mode,
    input  logic              wr_duty,
    input  logic              wr_dstg,
    input  logic              wr_per,
    input  logic              wr_pstg,
    input  logic [CNT_W-1:0]  wval,
    input  logic [PRES_W-1:0] wpres,
    input  logic              wpol,
    output logic              running,
    output logic              period_end,
    output logic              pwm,
    output logic [PRES_W-1:0] pres_o,
    output logic              pol_o,
    output logic [CNT_W-1:0]  duty_o,
    output logic [CNT_W-1:0]  per_o,
    output logic [CNT_W-1:0]  dstg_o,
    output logic [CNT_W-1:0]  pstg_o
);
    logic             tick;
    logic             stopping;
    logic             dpend, ppend;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_next;

    pwm_tick_gen #(.PRES_W(PRES_W), .PRES_MAX(PRES_MAX)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(running), .restart(start_req),
        .pres(pres_o), .tick(tick)
    );

    assign cnt_next   = (CNT_W+1)'(cnt) + (CNT_W+1)'(1);
    assign period_end = tick && (cnt_next >= (CNT_W+1)'(per_o));
    assign pwm        = (running && (cnt < duty_o)) ^ pol_o;

    // Run state and counter: start restarts; a stop waits for period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0; stopping <= 1'b0; cnt <= '0;
        end else if (start_req) begin
            running <= 1'b1; stopping <= 1'b0; cnt <= '0;
        end else if (period_end && stopping) begin
            running <= 1'b0; stopping <= 1'b0; cnt <= '0;
        end else begin
            if (stop_req && running) stopping <= 1'b1;
            if (tick) cnt <= period_end ? '0 : cnt + CNT_W'(1);
        end
    end

    // Mode word: prescaler exponent and polarity, applied at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pres_o <= '0; pol_o <= 1'b0;
        end else if (wr_mode) begin
            pres_o <= wpres; pol_o <= wpol;
        end
    end

    // Duty: a direct write wins; staged values land at period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_o <= '0; dstg_o <= '0; dpend <= 1'b0;
        end else if (wr_duty) begin
            duty_o <= wval; dpend <= 1'b0;
        end else begin
            if (period_end && dpend) begin duty_o <= dstg_o; dpend <= 1'b0; end
            if (wr_dstg) begin dstg_o <= wval; dpend <= 1'b1; end
        end
    end

    // Period: same staging rule as duty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_o <= '0; pstg_o <= '0; ppend <= 1'b0;
        end else if (wr_per) begin
            per_o <= wval; ppend <= 1'b0;
        end else begin
            if (period_end && ppend) begin per_o <= pstg_o; ppend <= 1'b0; end
            if (wr_pstg) begin pstg_o <= wval; ppend <= 1'b1; end
        end
    end

    // R4: the counter is back at zero right after a period ends.
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> (cnt == '0));
    // R9: a running channel keeps running until a period ends.
    p_hold_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !period_end) |=> running);
    // R7: a pending staged duty is the active duty after the boundary.
    p_apply_duty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && dpend && !wr_duty) |=> (duty_o == $past(dstg_o)));
endmodule

// File: rtl/pwm_ctrl.sv
// Module: pwm_ctrl
// Top level: register decode, global start/stop/running/flag registers
// and NCH channel instances. Reads are registered, so data appears the
// cycle after bus_rd. Reading the flag word clears it.
module pwm_ctrl
    import pwm_ctrl_pkg::*;
#(
    parameter int NCH    = NCH_DEF,
    parameter int CNT_W  = CNT_W_DEF,
    parameter int PRES_W = PRES_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic              in_glob, in_chan, rd_flag;
    logic [4:0]        off;
    logic [CH_W-1:0]   ch_idx;
    logic [NCH-1:0]    run_v, pe_v, flag;
    logic [DATA_W-1:0] rd_val;
    logic              unused_hi;

    logic [PRES_W-1:0] pres_a [NCH];
    logic              pol_a  [NCH];
    logic [CNT_W-1:0]  duty_a [NCH];
    logic [CNT_W-1:0]  per_a  [NCH];
    logic [CNT_W-1:0]  dstg_a [NCH];
    logic [CNT_W-1:0]  pstg_a [NCH];

    assign unused_hi = ^bus_wdata[DATA_W-1:CNT_W];

    // Address split into region, channel index and register offset.
    always_comb begin
        off     = bus_addr[4:0];
        ch_idx  = bus_addr[CH_LSB +: CH_W];
        in_glob = (bus_addr[ADDR_W-1:CH_LSB] == '0);
        in_chan = bus_addr[ADDR_W-1] &&
                  (bus_addr[ADDR_W-2:CH_LSB+CH_W] == '0);
        rd_flag = bus_rd && in_glob && (off == G_FLAG);
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel;
        assign sel = bus_wr && in_chan && (ch_idx == CH_W'(i));
        pwm_channel #(.CNT_W(CNT_W), .PRES_W(PRES_W), .PRES_MAX(PRES_MAX)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .start_req(bus_wr && in_glob && (off == G_START) && bus_wdata[i]),
            .stop_req (bus_wr && in_glob && (off == G_STOP)  && bus_wdata[i]),
            .wr_mode(sel && (off == C_MODE)),
            .wr_duty(sel && (off == C_DUTY)),
            .wr_dstg(sel && (off == C_DSTG)),
            .wr_per (sel && (off == C_PER)),
            .wr_pstg(sel && (off == C_PSTG)),
            .wval(bus_wdata[CNT_W-1:0]),
            .wpres(bus_wdata[PRES_W-1:0]),
            .wpol(bus_wdata[POL_BIT]),
            .running(run_v[i]), .period_end(pe_v[i]), .pwm(pwm_out[i]),
            .pres_o(pres_a[i]), .pol_o(pol_a[i]),
            .duty_o(duty_a[i]), .per_o(per_a[i]),
            .dstg_o(dstg_a[i]), .pstg_o(pstg_a[i])
        );
    end

    // Read multiplexer over global and channel registers.
    always_comb begin
        rd_val = '0;
        if (in_glob) begin
            if (off == G_RUN)  rd_val = DATA_W'(run_v);
            if (off == G_FLAG) rd_val = DATA_W'(flag);
        end else if (in_chan) begin
            case (off)
                C_MODE: begin
                    rd_val[PRES_W-1:0] = pres_a[ch_idx];
                    rd_val[POL_BIT]    = pol_a[ch_idx];
                end
                C_DUTY:  rd_val = DATA_W'(duty_a[ch_idx]);
                C_DSTG:  rd_val = DATA_W'(dstg_a[ch_idx]);
                C_PER:   rd_val = DATA_W'(per_a[ch_idx]);
                C_PSTG:  rd_val = DATA_W'(pstg_a[ch_idx]);
                default: rd_val = '0;
            endcase
        end
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    // Sticky completion flags; a read clears all but same-cycle sets.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= '0;
        else        flag <= pe_v | (rd_flag ? '0 : flag);
    end

    // R8: a flag read with no boundary in that cycle leaves the word empty.
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flag && pe_v == '0) |=> (flag == '0));
endmodule

// File: tb/pwm_ctrl_test.sv
module pwm_ctrl_test;
    localparam int CLK_NS = 10;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    pwm_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_run[NC], m_stop[NC], m_cnt[NC], m_pre[NC], m_duty[NC], m_per[NC];
    int m_dsg[NC], m_psg[NC], m_dp[NC], m_pp[NC], m_pres[NC], m_pol[NC];
    int m_flag;
    bit rd_chk;
    logic [31:0] exp_rd;

    function automatic logic [31:0] m_read(input int a);
        int c, o;
        if (a == 'h0C) begin
            m_read = 0;
            for (int i = 0; i < NC; i++) if (m_run[i] != 0) m_read[i] = 1'b1;
            return m_read;
        end
        if (a == 'h1C) return 32'(m_flag);
        if (a >= 'h200 && a < 'h200 + NC*32) begin
            c = (a - 'h200) / 32; o = a % 32;
            case (o)
                0:    return 32'((m_pol[c] << 9) | m_pres[c]);
                4:    return 32'(m_duty[c]);
                8:    return 32'(m_dsg[c]);
                12:   return 32'(m_per[c]);
                16:   return 32'(m_psg[c]);
                default: return 0;
            endcase
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        int a, v, c, o, newf, p, lim;
        bit glob, inch, tick, pe, en, dis;
        if (!rst_n) begin
            for (int i = 0; i < NC; i++) begin
                m_run[i] = 0; m_stop[i] = 0; m_cnt[i] = 0; m_pre[i] = 0;
                m_duty[i] = 0; m_per[i] = 0; m_dsg[i] = 0; m_psg[i] = 0;
                m_dp[i] = 0; m_pp[i] = 0; m_pres[i] = 0; m_pol[i] = 0;
            end
            m_flag = 0; rd_chk = 0;
        end else begin
            a = int'(bus_addr); v = int'(bus_wdata[15:0]);
            rd_chk = bus_rd;
            if (bus_rd) exp_rd = m_read(a);
            glob = (a < 'h20);
            inch = (a >= 'h200 && a < 'h200 + NC*32);
            c = inch ? (a - 'h200) / 32 : -1; o = a % 32;
            newf = 0;
            for (int i = 0; i < NC; i++) begin
                p = (m_pres[i] > 10) ? 10 : m_pres[i];
                lim = (1 << p) - 1;
                tick = (m_run[i] != 0) && (m_pre[i] == lim);
                pe = tick && (m_cnt[i] + 1 >= m_per[i]);
                en = bus_wr && glob && a == 'h04 && bus_wdata[i];
                dis = bus_wr && glob && a == 'h08 && bus_wdata[i];
                if (en) begin
                    m_run[i] = 1; m_stop[i] = 0; m_cnt[i] = 0; m_pre[i] = 0;
                end else if (pe && m_stop[i] != 0) begin
                    m_run[i] = 0; m_stop[i] = 0; m_cnt[i] = 0; m_pre[i] = 0;
                end else begin
                    if (dis && m_run[i] != 0) m_stop[i] = 1;
                    if (tick) begin m_cnt[i] = pe ? 0 : m_cnt[i] + 1; m_pre[i] = 0; end
                    else m_pre[i] = (m_run[i] != 0) ? m_pre[i] + 1 : 0;
                end
                if (bus_wr && c == i && o == 4) begin m_duty[i] = v; m_dp[i] = 0; end
                else begin
                    if (pe && m_dp[i] != 0) begin m_duty[i] = m_dsg[i]; m_dp[i] = 0; end
                    if (bus_wr && c == i && o == 8) begin m_dsg[i] = v; m_dp[i] = 1; end
                end
                if (bus_wr && c == i && o == 12) begin m_per[i] = v; m_pp[i] = 0; end
                else begin
                    if (pe && m_pp[i] != 0) begin m_per[i] = m_psg[i]; m_pp[i] = 0; end
                    if (bus_wr && c == i && o == 16) begin m_psg[i] = v; m_pp[i] = 1; end
                end
                if (bus_wr && c == i && o == 0) begin
                    m_pres[i] = int'(bus_wdata[3:0]); m_pol[i] = int'(bus_wdata[9]);
                end
                if (pe) newf |= (1 << i);
            end
            m_flag = newf | ((bus_rd && a == 'h1C) ? 0 : m_flag);
        end
    end

    // Compare outputs and read data with the model every clock (R4, R5, R8).
    always @(negedge clk) begin
        logic [3:0] exp_o;
        if (rst_n && !done) begin
            for (int i = 0; i < NC; i++)
                exp_o[i] = ((m_run[i] != 0 && m_cnt[i] < m_duty[i]) ? 1'b1 : 1'b0) ^ m_pol[i][0];
            chk("R4 model waveform", 32'(pwm_out), 32'(exp_o));
            if (rd_chk) chk("R8 model read data", bus_rdata, exp_rd);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bwrite(input int a, input logic [31:0] d);
        bus_addr = 10'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input int a, output logic [31:0] d);
        bus_addr = 10'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Count clocks with output bit ch high, starting at the current edge.
    task automatic count_hi(input int ch, input int n, output int hi);
        hi = 0;
        for (int k = 0; k < n; k++) begin
            if (pwm_out[ch]) hi++;
            @(negedge clk);
        end
    endtask

    function automatic int chb(input int ch, input int off);
        return 'h200 + ch*32 + off;
    endfunction

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int hi;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs", 32'(pwm_out), 0);
        bread('h0C, r); chk("R1 running", r, 0);
        bread('h1C, r); chk("R1 flags", r, 0);

        // R4: channel 0, period 10, duty 3, no prescale
        bwrite(chb(0,0), 32'h0);
        bwrite(chb(0,12), 32'd10);
        bwrite(chb(0,4), 32'd3);
        bwrite('h04, 32'h1);
        count_hi(0, 10, hi); chk("R4 active clocks ch0", 32'(hi), 3);

        // R3/R5: channel 1, p=2, period 5, duty 2, active low
        bwrite(chb(1,0), 32'h202);
        bwrite(chb(1,12), 32'd5);
        bwrite(chb(1,4), 32'd2);
        chk("R5 idle level active-low", 32'(pwm_out[1]), 1);
        bwrite('h04, 32'h2);
        count_hi(1, 20, hi); chk("R3 R5 high clocks ch1", 32'(hi), 12);
        // R2: start bits and zero bits
        bread('h0C, r); chk("R2 running after starts", r, 32'h3);
        bwrite('h04, 32'h0);
        bread('h0C, r); chk("R2 zero write no effect", r, 32'h3);

        // R10/R6: channel 2 constant levels
        bwrite(chb(2,12), 32'h0001_0004);
        bread(chb(2,12), r); chk("R10 period upper bits", r, 32'd4);
        bwrite(chb(2,4), 32'd0);
        bwrite('h04, 32'h4);
        count_hi(2, 12, hi); chk("R6 duty zero", 32'(hi), 0);
        bwrite(chb(2,4), 32'hABCD_FFFF);
        count_hi(2, 12, hi); chk("R6 R12 duty above period", 32'(hi), 12);
        bread(chb(2,4), r); chk("R10 duty upper bits", r, 32'hFFFF);

        // R3 clamp: p=15 acts as 10, period 2, duty 1
        bwrite('h08, 32'h4);
        idle(8);
        bread('h0C, r); chk("R9 ch2 stopped", 32'(r[2]), 0);
        bwrite(chb(2,0), 32'hF);
        bwrite(chb(2,12), 32'd2);
        bwrite(chb(2,4), 32'd1);
        bwrite('h04, 32'h4);
        count_hi(2, 2048, hi); chk("R3 clamp high clocks", 32'(hi), 1024);

        // R7/R8/R9: channel 3, period 200, duty 50
        bwrite(chb(3,0), 32'h0);
        bwrite(chb(3,12), 32'd200);
        bwrite(chb(3,4), 32'd50);
        bwrite('h04, 32'h8);
        bwrite(chb(3,8), 32'd120);
        bread(chb(3,4), r); chk("R7 duty held before boundary", r, 32'd50);
        idle(210);
        bread(chb(3,4), r); chk("R7 duty applied at boundary", r, 32'd120);
        bread('h1C, r); chk("R8 flag set", 32'(r[3]), 1);
        bread('h1C, r); chk("R8 flag cleared by read", 32'(r[3]), 0);
        bwrite('h08, 32'h8);
        bread('h0C, r); chk("R9 running until end", 32'(r[3]), 1);
        idle(200);
        bread('h0C, r); chk("R9 stopped after end", 32'(r[3]), 0);
        chk("R9 R5 inactive after stop", 32'(pwm_out[3]), 0);

        // R11: restart ch0 mid-period
        idle(4);
        bwrite('h04, 32'h1);
        chk("R11 restart at count zero", 32'(pwm_out[0]), 1);
        count_hi(0, 10, hi); chk("R11 active clocks after restart", 32'(hi), 3);

        // R12: direct duty write
        bwrite(chb(0,4), 32'd9);
        bread(chb(0,4), r); chk("R12 direct duty", r, 32'd9);
        count_hi(0, 10, hi); chk("R12 new duty in use", 32'(hi) >= 8 ? 32'd1 : 32'd0, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule